// File: doc/BRIEF.md
# Programmable-Flag Synchronous FIFO

A single-clock FIFO of parameterised width and depth (9 bits by 2048 words by default). It reports its fill state through a write-side flag, a read-side flag, a half-full flag and two threshold flags: almost-empty and almost-full. Each threshold flag compares the occupancy with its own offset register. Software, or a neighbouring offset register unit, loads each offset through a strobe and a value input.

A synchronous master reset empties the FIFO. It also latches the timing mode and loads both offsets with a default, picked between two parameter values by a select input. In standard mode the write-side and read-side flags mean full and empty, and a read returns its word on the clock after the request. In fall-through mode the same two outputs mean input-ready and output-ready, and the oldest word sits on the data output with no read request.

A synchronous partial reset empties the FIFO but keeps the mode and both offsets. A retransmit rewinds the read pointer to the first location, so the words written since the last reset can be read again. An asynchronous power-on reset puts the block into a known state.

Top module: `fifo_pf`

## Requirements
- R1: A write with `wen_i` high while the FIFO is not full stores `wdata_i` and raises the occupancy by one. A read with `ren_i` high while it is not empty removes the oldest word. Words leave in the order they were written. A write and a read in the same cycle leave the occupancy unchanged.
- R2: In standard mode (`fwft_sel_i`=0 at master reset), `wr_flag_o` is 1 exactly when the FIFO is full and `rd_flag_o` is 1 exactly when it is empty. `rdata_o` takes the word removed by a read after the clock edge that accepts the read, holds it until the next read, and reads 0 after any reset.
- R3: In fall-through mode (`fwft_sel_i`=1 at master reset), `wr_flag_o` is 1 when at least one location is free and `rd_flag_o` is 1 when at least one word is stored. While a word is stored, `rdata_o` shows the oldest word, including the first word written, without any read.
- R4: A write while full and a read while empty are ignored. They change neither the stored words nor the occupancy.
- R5: `hf_o` is 1 exactly when the occupancy is greater than DEPTH/2.
- R6: `ae_o` is 1 when the occupancy is less than or equal to the almost-empty offset. `af_o` is 1 when DEPTH minus the occupancy is less than or equal to the almost-full offset.
- R7: `ae_ld_i` loads `ae_off_i` into the almost-empty offset, and `af_ld_i` loads `af_off_i` into the almost-full offset, each independently, on the clock edge where the strobe is high.
- R8: `mrs_ni` low at a clock edge empties the FIFO and latches the mode from `fwft_sel_i`. It loads both offsets with DEF_LO when `ld_sel_i`=0 and with DEF_HI when `ld_sel_i`=1. It overrides every other input.
- R9: `prs_ni` low at a clock edge, with `mrs_ni` high, empties the FIFO and ignores that cycle's read, write and retransmit. It keeps the mode and both offsets.
- R10: `rt_ni` low at a clock edge, with both resets high, sets the read pointer to the first location and ignores that cycle's read. The occupancy becomes the number of words written since the last reset. This holds while no more than DEPTH words have been written since that reset.
- R11: While `rst_ni` is low, the FIFO is empty, in standard mode, with both offsets at DEF_LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| mrs_ni | input | 1 | Synchronous master reset, active low |
| prs_ni | input | 1 | Synchronous partial reset, active low |
| fwft_sel_i | input | 1 | Mode select sampled at master reset (1 = fall-through) |
| ld_sel_i | input | 1 | Default offset select sampled at master reset (1 = DEF_HI) |
| rt_ni | input | 1 | Retransmit, active low |
| wen_i | input | 1 | Write enable |
| wdata_i | input | DATA_W | Write data |
| ren_i | input | 1 | Read enable |
| ae_ld_i | input | 1 | Almost-empty offset load strobe |
| ae_off_i | input | $clog2(DEPTH) | Almost-empty offset value |
| af_ld_i | input | 1 | Almost-full offset load strobe |
| af_off_i | input | $clog2(DEPTH) | Almost-full offset value |
| rdata_o | output | DATA_W | Read data |
| wr_flag_o | output | 1 | Full (standard) or input-ready (fall-through) |
| rd_flag_o | output | 1 | Empty (standard) or output-ready (fall-through) |
| hf_o | output | 1 | Half-full |
| ae_o | output | 1 | Almost-empty |
| af_o | output | 1 | Almost-full |

## Verification
The bench builds the block with DEPTH=16, DATA_W=9, DEF_LO=3 and DEF_HI=6. With these values a few hundred random cycles fill the FIFO, wrap both pointers, and cross the half-full level and both threshold levels many times. Because DEPTH is small, a retransmit with every location written can also be reached between partial resets, and both default offsets give flag edges that the bench can see. Random offset loads of 0 to 15 cover the extremes of each threshold in both modes.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/fifo_pf_mem.sv
module fifo_pf_mem #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // async read port: fall-through output and standard capture register share it
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fifo_pf_ctrl.sv
module fifo_pf_ctrl #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mrs_ni,
  input  logic          prs_ni,
  input  logic          rt_ni,
  input  logic          wen_i,
  input  logic          ren_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic [CW-1:0] occ_o,
  output logic          wr_fire_o,
  output logic          rd_fire_o,
  output logic          clear_o
);
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] occ_q, wsince_q;
  logic          full, empty, clear, rewind, wr_ok, wr_fire, rd_fire;

  assign full   = occ_q == CW'(DEPTH);
  assign empty  = occ_q == '0;
  assign clear  = !mrs_ni || !prs_ni;
  assign rewind = !clear && !rt_ni;
  // on rewind the occupancy jumps to wsince, so the write guard must use it
  assign wr_ok   = rewind ? (wsince_q != CW'(DEPTH)) : !full;
  assign wr_fire = !clear && wen_i && wr_ok;
  assign rd_fire = !clear && !rewind && ren_i && !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      occ_q    <= '0;
      wsince_q <= '0;
    end else if (clear) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      occ_q    <= '0;
      wsince_q <= '0;
    end else begin
      if (wr_fire) begin
        wptr_q <= wptr_q + 1'b1;
        if (wsince_q != CW'(DEPTH)) wsince_q <= wsince_q + 1'b1;
      end
      if (rewind) begin
        rptr_q <= '0;
        occ_q  <= wsince_q + CW'(wr_fire);
      end else begin
        rptr_q <= rptr_q + AW'(rd_fire);
        occ_q  <= occ_q + CW'(wr_fire) - CW'(rd_fire);
      end
    end
  end

  assign wptr_o    = wptr_q;
  assign rptr_o    = rptr_q;
  assign occ_o     = occ_q;
  assign wr_fire_o = wr_fire;
  assign rd_fire_o = rd_fire;
  assign clear_o   = clear;
endmodule

// File: rtl/fifo_pf_cfg.sv
module fifo_pf_cfg
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH  = 2048,
  parameter int AW     = $clog2(DEPTH),
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mrs_ni,
  input  logic          fwft_sel_i,
  input  logic          ld_sel_i,
  input  logic          ae_ld_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic          af_ld_i,
  input  logic [AW-1:0] af_off_i,
  output fifo_mode_e    mode_o,
  output logic [AW-1:0] ae_off_o,
  output logic [AW-1:0] af_off_o
);
  localparam logic [AW-1:0] OFF_LO = AW'(DEF_LO);
  localparam logic [AW-1:0] OFF_HI = AW'(DEF_HI);

  fifo_mode_e    mode_q;
  logic [AW-1:0] ae_q, af_q, def_off;

  assign def_off = ld_sel_i ? OFF_HI : OFF_LO;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STD;
      ae_q   <= OFF_LO;
      af_q   <= OFF_LO;
    end else if (!mrs_ni) begin
      mode_q <= fwft_sel_i ? MODE_FWFT : MODE_STD;
      ae_q   <= def_off;
      af_q   <= def_off;
    end else begin
      if (ae_ld_i) ae_q <= ae_off_i;
      if (af_ld_i) af_q <= af_off_i;
    end
  end

  assign mode_o   = mode_q;
  assign ae_off_o = ae_q;
  assign af_off_o = af_q;
endmodule

// File: rtl/fifo_pf_flags.sv
module fifo_pf_flags
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic [CW-1:0] occ_i,
  input  fifo_mode_e    mode_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [AW-1:0] af_off_i,
  output logic          wr_flag_o,
  output logic          rd_flag_o,
  output logic          hf_o,
  output logic          ae_o,
  output logic          af_o
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_LVL = CW'(DEPTH / 2);

  logic          is_full, is_empty;
  logic [CW-1:0] free_cnt;

  assign is_full  = occ_i == FULL_LVL;
  assign is_empty = occ_i == '0;
  assign free_cnt = FULL_LVL - occ_i;

  always_comb begin
    if (mode_i == MODE_FWFT) begin
      wr_flag_o = !is_full;
      rd_flag_o = !is_empty;
    end else begin
      wr_flag_o = is_full;
      rd_flag_o = is_empty;
    end
  end

  assign hf_o = occ_i > HALF_LVL;
  assign ae_o = occ_i <= {1'b0, ae_off_i};
  assign af_o = free_cnt <= {1'b0, af_off_i};
endmodule

// File: rtl/fifo_pf.sv
module fifo_pf
  import fifo_pf_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 2048,
  parameter int DEF_LO = 127,
  parameter int DEF_HI = 1023,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrs_ni,
  input  logic              prs_ni,
  input  logic              fwft_sel_i,
  input  logic              ld_sel_i,
  input  logic              rt_ni,
  input  logic              wen_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ren_i,
  input  logic              ae_ld_i,
  input  logic [AW-1:0]     ae_off_i,
  input  logic              af_ld_i,
  input  logic [AW-1:0]     af_off_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wr_flag_o,
  output logic              rd_flag_o,
  output logic              hf_o,
  output logic              ae_o,
  output logic              af_o
);
  logic [AW-1:0]     wptr, rptr, ae_off, af_off;
  logic [CW-1:0]     occ;
  logic              wr_fire, rd_fire, clear;
  logic [DATA_W-1:0] mem_rdata, std_q;
  fifo_mode_e        mode;

  fifo_pf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .mrs_ni, .prs_ni, .rt_ni, .wen_i, .ren_i,
    .wptr_o(wptr), .rptr_o(rptr), .occ_o(occ),
    .wr_fire_o(wr_fire), .rd_fire_o(rd_fire), .clear_o(clear)
  );

  fifo_pf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i, .we_i(wr_fire), .waddr_i(wptr), .wdata_i,
    .raddr_i(rptr), .rdata_o(mem_rdata)
  );

  fifo_pf_cfg #(.DEPTH(DEPTH), .AW(AW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_cfg (
    .clk_i, .rst_ni, .mrs_ni, .fwft_sel_i, .ld_sel_i,
    .ae_ld_i, .ae_off_i, .af_ld_i, .af_off_i,
    .mode_o(mode), .ae_off_o(ae_off), .af_off_o(af_off)
  );

  fifo_pf_flags #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_flags (
    .occ_i(occ), .mode_i(mode), .ae_off_i(ae_off), .af_off_i(af_off),
    .wr_flag_o, .rd_flag_o, .hf_o, .ae_o, .af_o
  );

  // standard-mode output register: one clock read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          std_q <= '0;
    else if (clear)                       std_q <= '0;
    else if (rd_fire && mode == MODE_STD) std_q <= mem_rdata;
  end

  assign rdata_o = (mode == MODE_FWFT) ? mem_rdata : std_q;
endmodule

// File: rtl/fifo_pf_chk.sv
module fifo_pf_chk #(
  parameter int DEPTH  = 2048,
  parameter int AW     = $clog2(DEPTH),
  parameter int CW     = AW + 1,
  parameter int DEF_LO = 127
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mrs_ni,
  input logic          prs_ni,
  input logic          rt_ni,
  input logic          wen_i,
  input logic          ren_i,
  input logic          ld_sel_i,
  input logic          ae_ld_i,
  input logic          af_ld_i,
  input logic [CW-1:0] occ_i,
  input logic [AW-1:0] rptr_i,
  input logic          mode_i,
  input logic [AW-1:0] ae_off_i,
  input logic [AW-1:0] af_off_i,
  input logic          wr_flag_i,
  input logic          rd_flag_i
);
  logic run;
  assign run = mrs_ni && prs_ni && rt_ni;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= CW'(DEPTH)); // R4
  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && occ_i == CW'(DEPTH) && wen_i && !ren_i |=> occ_i == CW'(DEPTH)); // R4
  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run && occ_i == '0 && ren_i && !wen_i |=> occ_i == '0); // R4
  AST_OCC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> (occ_i == $past(occ_i) || occ_i == $past(occ_i) + 1'b1
             || occ_i + 1'b1 == $past(occ_i))); // R1
  AST_STD_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> !(wr_flag_i && rd_flag_i)); // R2
  AST_MRS_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mrs_ni && !ld_sel_i |=> ae_off_i == AW'(DEF_LO) && af_off_i == AW'(DEF_LO)
                             && occ_i == '0); // R8
  AST_PRS_KEEPS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_ni && !prs_ni && !ae_ld_i && !af_ld_i |=> $stable(ae_off_i) && $stable(af_off_i)
                                                  && $stable(mode_i) && occ_i == '0); // R9
  AST_RT_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs_ni && prs_ni && !rt_ni |=> rptr_i == '0); // R10
endmodule

bind fifo_pf fifo_pf_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .DEF_LO(DEF_LO)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mrs_ni(mrs_ni), .prs_ni(prs_ni), .rt_ni(rt_ni),
  .wen_i(wen_i), .ren_i(ren_i), .ld_sel_i(ld_sel_i), .ae_ld_i(ae_ld_i), .af_ld_i(af_ld_i),
  .occ_i(occ), .rptr_i(rptr), .mode_i(mode), .ae_off_i(ae_off), .af_off_i(af_off),
  .wr_flag_i(wr_flag_o), .rd_flag_i(rd_flag_o)
);

// File: tb/fifo_pf_bench.sv
module fifo_pf_bench;
  localparam int DATA_W = 9;
  localparam int DEPTH  = 16;
  localparam int DEF_LO = 3;
  localparam int DEF_HI = 6;
  localparam int AW     = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_ni = 1'b0, mrs_ni = 1'b1, prs_ni = 1'b1, rt_ni = 1'b1;
  logic fwft_sel = 1'b0, ld_sel = 1'b0, wen = 1'b0, ren = 1'b0;
  logic ae_ld = 1'b0, af_ld = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [AW-1:0] ae_off = '0, af_off = '0;
  logic [DATA_W-1:0] rdata;
  logic wr_flag, rd_flag, hf, ae, af;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [DATA_W-1:0] mq[$];
  logic [DATA_W-1:0] hist [DEPTH];
  logic [DATA_W-1:0] m_qreg;
  int m_total, m_ae, m_af;
  bit m_fwft;

  always #5 clk = ~clk;

  fifo_pf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_fifo_pf (
    .clk_i(clk), .rst_ni(rst_ni), .mrs_ni(mrs_ni), .prs_ni(prs_ni),
    .fwft_sel_i(fwft_sel), .ld_sel_i(ld_sel), .rt_ni(rt_ni),
    .wen_i(wen), .wdata_i(wdata), .ren_i(ren),
    .ae_ld_i(ae_ld), .ae_off_i(ae_off), .af_ld_i(af_ld), .af_off_i(af_off),
    .rdata_o(rdata), .wr_flag_o(wr_flag), .rd_flag_o(rd_flag),
    .hf_o(hf), .ae_o(ae), .af_o(af)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model_por();
    mq.delete(); m_total = 0; m_qreg = '0; m_fwft = 0; m_ae = DEF_LO; m_af = DEF_LO;
  endfunction

  function automatic void model_edge();
    bit do_rd, do_wr;
    if (!rst_ni) begin model_por(); return; end
    if (!mrs_ni) begin
      mq.delete(); m_total = 0; m_qreg = '0; m_fwft = fwft_sel;
      m_ae = ld_sel ? DEF_HI : DEF_LO; m_af = m_ae;
      return;
    end
    if (ae_ld) m_ae = ae_off;
    if (af_ld) m_af = af_off;
    if (!prs_ni) begin mq.delete(); m_total = 0; m_qreg = '0; return; end
    if (!rt_ni) begin
      mq.delete();
      for (int i = 0; i < m_total && i < DEPTH; i++) mq.push_back(hist[i]);
      do_rd = 0;
    end else do_rd = ren && mq.size() > 0;
    do_wr = wen && mq.size() < DEPTH;
    if (do_rd) begin
      if (m_fwft) void'(mq.pop_front()); else m_qreg = mq.pop_front();
    end
    if (do_wr) begin
      mq.push_back(wdata);
      if (m_total < DEPTH) hist[m_total] = wdata;
      m_total++;
    end
  endfunction

  task automatic check_outputs();
    int occ = mq.size();
    chk(m_fwft ? "R3 wr_flag" : "R2 wr_flag", wr_flag, m_fwft ? int'(occ != DEPTH) : int'(occ == DEPTH));
    chk(m_fwft ? "R3 rd_flag" : "R2 rd_flag", rd_flag, m_fwft ? int'(occ != 0) : int'(occ == 0));
    chk("R5 hf", hf, int'(occ > DEPTH / 2));
    chk("R6 ae", ae, int'(occ <= m_ae));
    chk("R6 af", af, int'(DEPTH - occ <= m_af));
    if (!m_fwft) chk("R1/R2 rdata", rdata, m_qreg);
    else if (occ > 0) chk("R3 rdata", rdata, mq[0]);
  endtask

  // inputs were set after a falling edge; apply one rising edge, then check
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_outputs();
    mrs_ni = 1'b1; prs_ni = 1'b1; rt_ni = 1'b1; wen = 1'b0; ren = 1'b0;
    ae_ld = 1'b0; af_ld = 1'b0;
  endtask

  task automatic do_mrs(bit f, bit l);
    mrs_ni = 1'b0; fwft_sel = f; ld_sel = l; tick();
  endtask

  task automatic wr(logic [DATA_W-1:0] d);
    wen = 1'b1; wdata = d; tick();
  endtask

  task automatic rd();
    ren = 1'b1; tick();
  endtask

  task automatic random_run(int n, int wpct, int rpct);
    for (int i = 0; i < n; i++) begin
      wen = ($urandom % 100) < wpct;
      ren = ($urandom % 100) < rpct;
      wdata = DATA_W'($urandom);
      if ($urandom % 100 < 2 && m_total <= DEPTH) rt_ni = 1'b0;
      if ($urandom % 100 < 1) prs_ni = 1'b0;
      if ($urandom % 100 < 2) begin ae_ld = 1'b1; ae_off = AW'($urandom); end
      if ($urandom % 100 < 2) begin af_ld = 1'b1; af_off = AW'($urandom); end
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_por();
    #1;
    // R11: state while power-on reset is held
    chk("R11 wr_flag", wr_flag, 0);
    chk("R11 rd_flag", rd_flag, 1);
    chk("R11 ae", ae, 1);
    chk("R11 rdata", rdata, 0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_outputs();

    // R8: master reset into standard mode, low default offsets
    do_mrs(0, 0);
    chk("R8 rd_flag empty", rd_flag, 1);

    // R4: overfill then overdrain
    for (int i = 0; i < DEPTH + 3; i++) wr(DATA_W'(9'h100 + i));
    chk("R4 full after extra writes", wr_flag, 1);
    for (int i = 0; i < DEPTH; i++) rd();
    chk("R4 empty after DEPTH reads", rd_flag, 1);
    chk("R4 last word read", rdata, 9'h100 + DEPTH - 1);
    rd(); rd();
    wr(9'h1AB); rd();
    chk("R4 word after ignored reads", rdata, 9'h1AB);

    // R7: programmed offsets
    ae_ld = 1'b1; ae_off = 4'd10; af_ld = 1'b1; af_off = 4'd2; tick();
    for (int i = 0; i < 10; i++) wr(DATA_W'(i));
    chk("R7 ae at offset", ae, 1);
    wr(9'h0AA);
    chk("R7 ae above offset", ae, 0);
    for (int i = 0; i < 3; i++) wr(DATA_W'(i));
    chk("R7 af at free=2", af, 1);

    // R9: partial reset keeps offsets
    prs_ni = 1'b0; wen = 1'b1; tick();
    chk("R9 empty after partial reset", rd_flag, 1);
    for (int i = 0; i < 11; i++) wr(DATA_W'(i));
    chk("R9 ae offset kept", ae, 0);

    // R10: retransmit
    prs_ni = 1'b0; tick();
    for (int i = 0; i < 5; i++) wr(DATA_W'(9'h050 + i));
    rd(); rd(); rd();
    rt_ni = 1'b0; tick();
    rd();
    chk("R10 first word again", rdata, 9'h050);

    // R8 + R3: fall-through mode, high defaults
    do_mrs(1, 1);
    chk("R8 fwft input ready", wr_flag, 1);
    chk("R8 fwft output not ready", rd_flag, 0);
    chk("R8 ae with high default", ae, 1);
    wr(9'h055);
    chk("R3 first word falls through", rdata, 9'h055);
    random_run(3000, 60, 45);
    random_run(2000, 40, 65);

    // back to standard mode
    do_mrs(0, 1);
    random_run(3000, 60, 45);
    random_run(2000, 40, 65);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule